// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block is the digital sequencer and serial port of a zero-latency delta-sigma converter. It runs a fixed-length conversion, falls asleep holding the result, and shifts that result out as a 32-bit word when the host pulls chip-select low. The conversion result arrives on a parallel input one bit wider than the code, so that inputs beyond half the reference in either direction can be recognised and given their own out-of-range codes. The conversion time is a cycle count of the system clock, so an external system clock scales the timing directly.

The serial clock pin can be driven by the block or by the host. The direction is chosen by the level on that pin during reset and again at every chip-select fall: high selects the internal clock, low selects the external one. Outside a transfer, with chip-select low, the data line shows whether a conversion is still running. Raising chip-select during a transfer abandons it and starts a new conversion. A completed transfer also starts a new conversion without waiting for chip-select.

Top module: `dsadc_serial_ctrl`

## Requirements
- R1: `sdo_oe` is 0 whenever `cs_n` is high and 1 whenever `cs_n` is low.
- R2: A conversion lasts exactly `CONV_CYCLES` clock cycles and is followed by sleep on its own. Sleep lasts as long as `cs_n` stays high, and a later `cs_n` fall begins output with no further conversion.
- R3: With `cs_n` low, `sdo_o` reads 1 while a conversion runs and 0 once the result waits in sleep.
- R4: The word is 32 bits, sent MSB first. Bit 31 is the status (0 when sent) and bit 30 is 0. Bit 29 is the sign (1 for zero or positive). Bit 28 is the out-of-range flag. Bits 27:4 hold the low 24 bits of the two's-complement result, and bits 3:0 are 0.
- R5: A sample above 2^23-1 gives sign 1, flag 1 and data 0. A sample below -2^23 gives sign 0, flag 1 and data all ones. Both limit values themselves are coded in range with flag 0.
- R6: `sdo_o` changes during output only after a falling serial-clock edge. In external mode the falling edges of `sck_i` advance the word.
- R7: A rise of `cs_n` during output aborts the transfer and starts a new conversion in the next cycle.
- R8: After the 32nd falling edge, a new conversion starts at once while `cs_n` stays low, and `sdo_o` returns to 1.
- R9: The clock mode is taken from `sck_i` during reset and at each `cs_n` fall, with 1 meaning internal and 0 meaning external. `sck_pullup_en` is 1 exactly in internal mode, and the mode holds between `cs_n` falls.
- R10: In internal mode `sck_oe` is 1 only during output. `sck_o` idles low, and its period is `2*HALF_DIV` clock cycles.
- R11: The result is captured at the end of the conversion. A later change of `sample_i` does not alter the word sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select and wake-up |
| sck_i | input | 1 | Level seen on the serial clock pin |
| sck_o | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sck_pullup_en | output | 1 | Weak pull-up enable for the serial clock pin |
| sdo_o | output | 1 | Serial data or conversion status |
| sdo_oe | output | 1 | Drive enable for the serial data pin |
| sample_i | input | DW+1 | Signed conversion result, one bit of headroom |

## Verification
The hardest case to reach is an abort part-way through a word. The bench clocks the host side itself, stops after a few bits and raises chip-select in a chosen cycle, then measures the time to the next ready status to show that the conversion restarted from zero. A related case is a result that goes stale while the block sleeps. There the sample input changes after the conversion has ended with chip-select high, and the later readout must still carry the earlier value.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
   typedef enum logic [1:0] {
      ST_CONV  = 2'd0,
      ST_SLEEP = 2'd1,
      ST_DOUT  = 2'd2
   } dsadc_state_e;
endpackage

// File: rtl/dsadc_conv_timer.sv
module dsadc_conv_timer #(
   parameter int CONV_CYCLES = 163840
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

   logic [CW-1:0] cnt;

   initial assert (CONV_CYCLES >= 2) else $error("CONV_CYCLES must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assign done = run && (cnt == LAST);

   // R2: a conversion never ends in the cycle it starts
   p_no_early_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> !done);
endmodule

// File: rtl/dsadc_code_fmt.sv
module dsadc_code_fmt #(
   parameter int DW = 24,
   parameter int WW = 32
) (
   input  logic signed [DW:0] sample,
   output logic [WW-1:0]      word
);
   localparam int HEAD = DW + 4;
   localparam int PAD  = WW - HEAD;
   localparam logic signed [DW:0] HI = $signed({2'b00, {(DW-1){1'b1}}});
   localparam logic signed [DW:0] LO = $signed({2'b11, {(DW-1){1'b0}}});

   initial assert (WW >= DW + 4) else $error("word too short for flags and data");

   logic          over, under;
   logic [HEAD-1:0] head;

   always_comb begin
      over  = (sample > HI);
      under = (sample < LO);
      if (over)       head = {2'b00, 1'b1, 1'b1, {DW{1'b0}}};
      else if (under) head = {2'b00, 1'b0, 1'b1, {DW{1'b1}}};
      else            head = {2'b00, ~sample[DW], 1'b0, sample[DW-1:0]};
   end

   generate
      if (PAD > 0) begin : g_pad
         assign word = {head, {PAD{1'b0}}};
      end else begin : g_nopad
         assign word = head;
      end
   endgenerate
endmodule

// File: rtl/dsadc_sck_engine.sv
module dsadc_sck_engine #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic int_mode,
   input  logic sck_i,
   output logic sck_gen,
   output logic fall
);
   logic tick;
   logic sck_q;

   initial assert (HALF_DIV >= 1) else $error("HALF_DIV must be at least 1");

   generate
      if (HALF_DIV == 1) begin : g_fast
         assign tick = active;
      end else begin : g_div
         localparam int DVW = $clog2(HALF_DIV);
         localparam logic [DVW-1:0] DLAST = DVW'(HALF_DIV - 1);
         logic [DVW-1:0] div;
         always_ff @(posedge clk) begin
            if (!rst_n || !active) div <= '0;
            else if (div == DLAST) div <= '0;
            else div <= div + 1'b1;
         end
         assign tick = active && (div == DLAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         sck_gen <= 1'b0;
      end else begin
         sck_q <= sck_i;
         if (!active) sck_gen <= 1'b0;
         else if (tick) sck_gen <= ~sck_gen;
      end
   end

   assign fall = active && (int_mode ? (tick && sck_gen) : (sck_q && !sck_i));
endmodule

// File: rtl/dsadc_serial_ctrl.sv
module dsadc_serial_ctrl
   import dsadc_pkg::*;
#(
   parameter int DW          = 24,
   parameter int WW          = 32,
   parameter int CONV_CYCLES = 163840,
   parameter int HALF_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sck_i,
   output logic             sck_o,
   output logic             sck_oe,
   output logic             sck_pullup_en,
   output logic             sdo_o,
   output logic             sdo_oe,
   input  logic signed [DW:0] sample_i
);
   localparam int BCW = $clog2(WW);
   localparam logic [BCW-1:0] BLAST = BCW'(WW - 1);

   dsadc_state_e   state;
   logic           cs_q, int_mode;
   logic [WW-1:0]  shreg, word;
   logic [BCW-1:0] bit_cnt;
   logic           conv_done, sck_fall, cs_rise, cs_fall;

   assign cs_rise = cs_n && !cs_q;
   assign cs_fall = !cs_n && cs_q;

   dsadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(state == ST_CONV), .done(conv_done));

   dsadc_code_fmt #(.DW(DW), .WW(WW)) u_fmt (.sample(sample_i), .word(word));

   dsadc_sck_engine #(.HALF_DIV(HALF_DIV)) u_sck (
      .clk(clk), .rst_n(rst_n), .active(state == ST_DOUT), .int_mode(int_mode),
      .sck_i(sck_i), .sck_gen(sck_o), .fall(sck_fall));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         int_mode <= sck_i;
         state    <= ST_CONV;
         shreg    <= '0;
         bit_cnt  <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_fall) int_mode <= sck_i;
         unique case (state)
            ST_CONV: if (conv_done) begin
               state   <= ST_SLEEP;
               shreg   <= word;
               bit_cnt <= '0;
            end
            ST_SLEEP: if (!cs_n) state <= ST_DOUT;
            ST_DOUT: begin
               if (cs_rise) state <= ST_CONV;
               else if (sck_fall) begin
                  if (bit_cnt == BLAST) state <= ST_CONV;
                  else begin
                     shreg   <= shreg << 1;
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_CONV;
         endcase
      end
   end

   assign sdo_oe        = !cs_n;
   assign sdo_o         = (state == ST_DOUT) ? shreg[WW-1] : (state == ST_CONV);
   assign sck_oe        = int_mode && (state == ST_DOUT);
   assign sck_pullup_en = int_mode;

   // R7: chip-select rise during output restarts conversion
   p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DOUT && cs_rise) |=> state == ST_CONV);
   // R2: sleep holds while chip-select stays high
   p_sleep_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && cs_n) |=> state == ST_SLEEP);
   // R9: mode follows the clock pin level at chip-select fall
   p_mode_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> int_mode == $past(sck_i));
   // R8: last falling edge starts a new conversion
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DOUT && !cs_rise && sck_fall && bit_cnt == BLAST) |=> state == ST_CONV);
   // R6: data holds between falling edges
   p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DOUT && $past(state == ST_DOUT) && !$past(sck_fall)) |-> $stable(sdo_o));
endmodule

// File: tb/dsadc_serial_ctrl_bench.sv
module dsadc_serial_ctrl_bench;
   localparam int DW = 24;
   localparam int WW = 32;
   localparam int CONV = 40;
   localparam int HALF = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic tb_drive = 1'b1;
   logic tb_sck = 1'b0;
   logic signed [DW:0] sample_i = '0;
   logic sck_o, sck_oe, sck_pullup_en, sdo_o, sdo_oe, sck_pad;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   assign sck_pad = sck_oe ? sck_o : (tb_drive ? tb_sck : sck_pullup_en);

   dsadc_serial_ctrl #(.DW(DW), .WW(WW), .CONV_CYCLES(CONV), .HALF_DIV(HALF)) u_dsadc_serial_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_i(sck_pad), .sck_o(sck_o),
      .sck_oe(sck_oe), .sck_pullup_en(sck_pullup_en), .sdo_o(sdo_o),
      .sdo_oe(sdo_oe), .sample_i(sample_i));

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic signed [DW:0] s);
      if (s > 25'sd8388607) return {4'b0011, 24'h000000, 4'h0};
      else if (s < -25'sd8388608) return {4'b0001, 24'hFFFFFF, 4'h0};
      else return {2'b00, ~s[DW], 1'b0, s[DW-1:0], 4'h0};
   endfunction

   task automatic ext_shift(input int nb, output logic [31:0] w, output int unst);
      logic b1, b2;
      w = '0;
      unst = 0;
      for (int i = 0; i < nb; i++) begin
         @(negedge clk) tb_sck = 1'b1;
         @(negedge clk) b1 = sdo_o;
         @(negedge clk) b2 = sdo_o;
         tb_sck = 1'b0;
         @(negedge clk);
         @(negedge clk);
         w[31-i] = b1;
         if (b1 !== b2) unst++;
      end
   endtask

   task automatic wait_ready(input string req);
      int n = 0;
      while (sdo_o !== 1'b0 && n < 4 * CONV) begin
         @(negedge clk);
         n++;
      end
      check(req, "ready status reached", {31'b0, sdo_o}, 32'd0);
   endtask

   task automatic t_reset_and_first;
      logic [31:0] w;
      int unst;
      int n = 0;
      sample_i = 25'sh0123456;
      repeat (4) @(negedge clk);
      check("R1", "sdo_oe in reset with cs high", {31'b0, sdo_oe}, 32'd0);
      check("R9", "pull-up after reset with pin low", {31'b0, sck_pullup_en}, 32'd0);
      check("R10", "sck_oe after reset", {31'b0, sck_oe}, 32'd0);
      rst_n = 1'b1;
      cs_n = 1'b0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            check("R1", "sdo_oe with cs low", {31'b0, sdo_oe}, 32'd1);
            check("R3", "status while converting", {31'b0, sdo_o}, 32'd1);
         end
         if (sdo_o === 1'b0 || n > 4 * CONV) break;
      end
      check("R2", "conversion length", n, CONV);
      ext_shift(32, w, unst);
      check("R4", "word positive", w, exp_word(25'sh0123456));
      check("R6", "data stable between falls", unst, 0);
      @(negedge clk);
      check("R8", "status after last bit", {31'b0, sdo_o}, 32'd1);
   endtask

   task automatic t_sleep_hold;
      logic [31:0] w;
      int unst;
      sample_i = -25'sd1000;
      cs_n = 1'b1;
      repeat (CONV + 10) @(negedge clk);
      check("R1", "sdo_oe with cs high", {31'b0, sdo_oe}, 32'd0);
      sample_i = 25'sd777;
      repeat (2 * CONV) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R2", "result ready at wake without conversion", {31'b0, sdo_o}, 32'd0);
      ext_shift(32, w, unst);
      check("R11", "word captured before sample change", w, exp_word(-25'sd1000));
   endtask

   task automatic t_abort;
      logic [31:0] w;
      int unst;
      int n = 0;
      sample_i = -25'sd5;
      wait_ready("R3");
      ext_shift(5, w, unst);
      @(negedge clk) cs_n = 1'b1;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) cs_n = 1'b0;
         if (n == 2) check("R7", "converting after abort", {31'b0, sdo_o}, 32'd1);
         if ((n > 2 && sdo_o === 1'b0) || n > 4 * CONV) break;
      end
      check("R7", "restart length after abort", n, CONV + 1);
      ext_shift(32, w, unst);
      check("R4", "word negative", w, exp_word(-25'sd5));
   endtask

   task automatic t_range;
      logic signed [DW:0] vals [6];
      logic [31:0] w;
      int unst;
      vals[0] = 25'sd8388607;
      vals[1] = -25'sd8388608;
      vals[2] = 25'sd8388608;
      vals[3] = -25'sd8388609;
      vals[4] = 25'sd0;
      vals[5] = -25'sd16777216;
      for (int i = 0; i < 6; i++) begin
         sample_i = vals[i];
         wait_ready("R5");
         ext_shift(32, w, unst);
         check("R5", $sformatf("range code for value %0d", vals[i]), w, exp_word(vals[i]));
      end
   endtask

   task automatic t_internal;
      logic [31:0] w = '0;
      int nbits = 0;
      int t = 0;
      int r0 = 0;
      int r1 = 0;
      logic prev = 1'b1;
      sample_i = 25'sh0ABCDEF;
      cs_n = 1'b1;
      tb_sck = 1'b1;
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk) tb_drive = 1'b0;
      check("R9", "pull-up in internal mode", {31'b0, sck_pullup_en}, 32'd1);
      check("R10", "sck_oe while converting", {31'b0, sck_oe}, 32'd0);
      while (sck_oe !== 1'b1 && t < 4 * CONV) begin
         @(negedge clk);
         t++;
      end
      prev = sck_pad;
      check("R10", "clock idles low at start", {31'b0, sck_pad}, 32'd0);
      t = 0;
      while (nbits < 32 && t < 2000) begin
         @(negedge clk);
         t++;
         if (prev === 1'b0 && sck_pad === 1'b1) begin
            w[31-nbits] = sdo_o;
            if (nbits == 0) r0 = t;
            if (nbits == 1) r1 = t;
            nbits++;
         end
         prev = sck_pad;
      end
      check("R10", "internal clock period", r1 - r0, 2 * HALF);
      check("R4", "word in internal mode", w, exp_word(25'sh0ABCDEF));
      repeat (2 * HALF + 2) @(negedge clk);
      check("R10", "sck_oe released after output", {31'b0, sck_oe}, 32'd0);
      check("R8", "status after internal readout", {31'b0, sdo_o}, 32'd1);
   endtask

   task automatic t_back_external;
      cs_n = 1'b1;
      tb_drive = 1'b1;
      tb_sck = 1'b0;
      repeat (3) @(negedge clk);
      check("R9", "mode held while cs high", {31'b0, sck_pullup_en}, 32'd1);
      cs_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R9", "external mode latched at cs fall", {31'b0, sck_pullup_en}, 32'd0);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      t_reset_and_first();
      t_sleep_hold();
      t_abort();
      t_range();
      t_internal();
      t_back_external();
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end
endmodule